// File: doc/BRIEF.md
# Fetch Thread Selector

This block chooses which hardware thread a multithreaded fetch stage serves in each fetch slot of a cycle. Each thread reports a 3-bit state code and has an active bit. A 2-bit policy input selects one of four rules: always thread 0, rotating priority, least instruction-queue occupancy, or least load/store-queue occupancy. For each slot the block returns a thread id together with a "none" flag, which says that no thread may fetch in that slot.

The rotating policy keeps an ordered list of thread ids. A grant takes the first eligible thread from the head of the list and moves it to the tail. Slots in the same cycle work in sequence: each slot scans the list as the slot before it left it, and the result of the last slot is registered at the clock edge. Once a slot finds no thread, every later slot in that cycle also reports none. A drain request or a low fetch enable suppresses every slot. When only one thread is configured, the policy input is ignored.

All pins are plain control and status signals. The grants are combinational from the inputs and the registered order, and nothing at the edge of the block is buffered or handshaked.

Top module: `fetch_thread_selector`

## Requirements
- R1: A thread is eligible only when its active bit is 1 and its state code is 0 (running), 1 (idle) or 6 (fill complete). Codes 2 (blocked), 3 (squashing), 4 (waiting on a miss), 5 (waiting to retry) and 7 never make a thread eligible.
- R2: With policy 1 (rotating), a slot grants the first eligible thread counted from the head of the order list. That thread is removed from its position, the threads behind it move forward by one, and it is placed at the tail.
- R3: After a synchronous reset (rst_n low at a rising edge) the order list holds the ids 0 to NUM_THREADS-1 in ascending order, with thread 0 at the head.
- R4: A slot with no eligible thread drives sel_none to 1 and its sel_tid field to 0.
- R5: Slot k+1 sees the order list as slot k left it. If a slot reports none, every later slot in the same cycle also reports none.
- R6: When drain_req is 1 or fetch_en is 0, every slot reports none and the order list keeps its value.
- R7: With policy 2 the block grants the eligible thread with the lowest iq_occ, and with policy 3 the eligible thread with the lowest lsq_occ. A tie goes to the lower id. These policies do not change the order list.
- R8: With policy 0 and more than one thread configured, every enabled slot grants thread 0 whatever its state or active bit.
- R9: With NUM_THREADS = 1 the policy input is ignored. Each enabled slot grants thread 0 exactly when thread 0 is eligible.
- R10: The order list changes only at a clock edge in which the rotating policy granted a thread in slot 0. Otherwise it stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_en | input | 1 | Fetch slots are requested this cycle |
| drain_req | input | 1 | Drain pending; suppresses all grants |
| policy | input | 2 | 0 thread 0 only, 1 rotating, 2 least IQ, 3 least LSQ |
| thread_state | input | NUM_THREADS*3 | Per-thread state code, thread t at bits [3t+2:3t] |
| thread_active | input | NUM_THREADS | Per-thread active bit |
| iq_occ | input | NUM_THREADS*OCC_W | Per-thread instruction-queue occupancy |
| lsq_occ | input | NUM_THREADS*OCC_W | Per-thread load/store-queue occupancy |
| sel_none | output | NUM_SLOTS | Per slot: no thread selected |
| sel_tid | output | NUM_SLOTS*TID_W | Per slot: selected thread id, slot s at [s*TID_W +: TID_W] |

## Verification
The four-thread configuration is driven through every combination of the four 3-bit state codes, under all four policies. Active masks and small occupancy values (0 to 3) come from a pseudo-random sequence, and the small value range makes ties between occupancies common. These sweeps show whether the eligibility decode, the head-first scan with its move to the tail, and the tie-break toward the lower id hold in every combination. Drain and fetch-enable gaps are mixed into the sweeps, which shows that the order list is left unchanged in cycles without a grant. Directed sequences after reset check the ascending start order and a list made up entirely of ineligible states. A single-thread instance is swept over every state code, active bit and policy, to show that the policy is ignored there.

// File: rtl/fsel_pkg.sv
package fsel_pkg;

  localparam int STATE_W = 3;

  typedef enum logic [2:0] {
    TS_RUN        = 3'd0,
    TS_IDLE       = 3'd1,
    TS_BLOCKED    = 3'd2,
    TS_SQUASH     = 3'd3,
    TS_MISS_WAIT  = 3'd4,
    TS_RETRY_WAIT = 3'd5,
    TS_FILL_DONE  = 3'd6,
    TS_SPARE      = 3'd7
  } thr_state_e;

  typedef enum logic [1:0] {
    POL_FIXED0    = 2'd0,
    POL_ROTATE    = 2'd1,
    POL_IQ_LEAST  = 2'd2,
    POL_LSQ_LEAST = 2'd3
  } pick_policy_e;

  function automatic logic state_can_fetch(input logic [STATE_W-1:0] st);
    return (st == TS_RUN) || (st == TS_IDLE) || (st == TS_FILL_DONE);
  endfunction

endpackage

// File: rtl/fsel_eligibility.sv
module fsel_eligibility
  import fsel_pkg::*;
#(
  parameter int NT = 4
) (
  input  logic [NT*STATE_W-1:0] state_flat,
  input  logic [NT-1:0]         active,
  output logic [NT-1:0]         elig
);

  for (genvar t = 0; t < NT; t++) begin : g_thr
    assign elig[t] = active[t] & state_can_fetch(state_flat[t*STATE_W +: STATE_W]);
  end

endmodule

// File: rtl/fsel_rotate_slot.sv
module fsel_rotate_slot #(
  parameter int NT = 4,
  parameter int TW = 2
) (
  input  logic                  en,
  input  logic [NT-1:0]         elig,
  input  logic [NT-1:0][TW-1:0] order_in,
  output logic                  found,
  output logic [TW-1:0]         tid,
  output logic [NT-1:0][TW-1:0] order_out
);

  logic          hit;
  logic [TW-1:0] pos;

  // first eligible entry counted from the head
  always_comb begin
    hit = 1'b0;
    pos = '0;
    for (int i = 0; i < NT; i++) begin
      if (!hit && elig[order_in[i]]) begin
        hit = 1'b1;
        pos = TW'(i);
      end
    end
  end

  assign found = en & hit;
  assign tid   = found ? order_in[pos] : '0;

  // close the gap and re-append the granted id at the tail
  always_comb begin
    order_out = order_in;
    if (found) begin
      for (int i = 0; i < NT - 1; i++) begin
        if (i >= int'(pos)) order_out[i] = order_in[i+1];
      end
      order_out[NT-1] = order_in[pos];
    end
  end

endmodule

// File: rtl/fsel_least_occ.sv
module fsel_least_occ #(
  parameter int NT = 4,
  parameter int OW = 5,
  parameter int TW = 2
) (
  input  logic [NT-1:0]    elig,
  input  logic [NT*OW-1:0] occ_flat,
  output logic             found,
  output logic [TW-1:0]    tid
);

  logic [OW-1:0] best;

  // strict less-than keeps the lower id on a tie
  always_comb begin
    found = 1'b0;
    tid   = '0;
    best  = '0;
    for (int t = 0; t < NT; t++) begin
      if (elig[t] && (!found || occ_flat[t*OW +: OW] < best)) begin
        found = 1'b1;
        best  = occ_flat[t*OW +: OW];
        tid   = TW'(t);
      end
    end
  end

endmodule

// File: rtl/fetch_thread_selector.sv
module fetch_thread_selector
  import fsel_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int NUM_SLOTS   = 2,
  parameter int OCC_W       = 5,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         fetch_en,
  input  logic                         drain_req,
  input  logic [1:0]                   policy,
  input  logic [NUM_THREADS*STATE_W-1:0] thread_state,
  input  logic [NUM_THREADS-1:0]       thread_active,
  input  logic [NUM_THREADS*OCC_W-1:0] iq_occ,
  input  logic [NUM_THREADS*OCC_W-1:0] lsq_occ,
  output logic [NUM_SLOTS-1:0]         sel_none,
  output logic [NUM_SLOTS*TID_W-1:0]   sel_tid
);

  localparam bit MULTI = (NUM_THREADS > 1);

  logic [NUM_THREADS-1:0]                         elig;
  logic [NUM_THREADS-1:0][TID_W-1:0]              order_q;
  logic [NUM_SLOTS:0][NUM_THREADS-1:0][TID_W-1:0] chain;
  logic [NUM_SLOTS-1:0]                           slot_en;
  logic [NUM_SLOTS-1:0]                           slot_found;
  logic                                           rot_mode;
  logic                                           rr_commit;
  logic                                           iq_found, lsq_found;
  logic [TID_W-1:0]                               iq_tid, lsq_tid;

  fsel_eligibility #(.NT(NUM_THREADS)) i_elig (
    .state_flat (thread_state),
    .active     (thread_active),
    .elig       (elig)
  );

  fsel_least_occ #(.NT(NUM_THREADS), .OW(OCC_W), .TW(TID_W)) i_iq_pick (
    .elig     (elig),
    .occ_flat (iq_occ),
    .found    (iq_found),
    .tid      (iq_tid)
  );

  fsel_least_occ #(.NT(NUM_THREADS), .OW(OCC_W), .TW(TID_W)) i_lsq_pick (
    .elig     (elig),
    .occ_flat (lsq_occ),
    .found    (lsq_found),
    .tid      (lsq_tid)
  );

  assign rot_mode   = MULTI && (policy == POL_ROTATE);
  assign slot_en[0] = fetch_en & ~drain_req;
  assign chain[0]   = order_q;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic             rot_found;
    logic [TID_W-1:0] rot_tid;
    logic             found_g;
    logic [TID_W-1:0] tid_g;

    fsel_rotate_slot #(.NT(NUM_THREADS), .TW(TID_W)) i_rot (
      .en        (slot_en[s] & rot_mode),
      .elig      (elig),
      .order_in  (chain[s]),
      .found     (rot_found),
      .tid       (rot_tid),
      .order_out (chain[s+1])
    );

    always_comb begin
      found_g = 1'b0;
      tid_g   = '0;
      if (!MULTI) begin
        found_g = slot_en[s] & elig[0];
      end else begin
        case (policy)
          POL_FIXED0: found_g = slot_en[s];
          POL_ROTATE: begin
            found_g = rot_found;
            tid_g   = rot_tid;
          end
          POL_IQ_LEAST: begin
            found_g = slot_en[s] & iq_found;
            tid_g   = found_g ? iq_tid : '0;
          end
          default: begin
            found_g = slot_en[s] & lsq_found;
            tid_g   = found_g ? lsq_tid : '0;
          end
        endcase
      end
    end

    assign slot_found[s]               = found_g;
    assign sel_none[s]                 = ~found_g;
    assign sel_tid[s*TID_W +: TID_W]   = tid_g;

    if (s < NUM_SLOTS - 1) begin : g_next
      assign slot_en[s+1] = slot_en[s] & found_g;
    end

    // R1: a granted slot names an eligible thread unless the fixed rule applies
    a_r1_grant_eligible: assert property (@(posedge clk) disable iff (!rst_n)
      (found_g && (!MULTI || policy != POL_FIXED0)) |-> elig[tid_g]);

    if (s > 0) begin : g_stop
      // R5: once a slot comes up empty, later slots stay empty
      a_r5_stop_after_none: assert property (@(posedge clk) disable iff (!rst_n)
        sel_none[s-1] |-> sel_none[s]);
    end
  end

  assign rr_commit = rot_mode & slot_en[0] & slot_found[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_THREADS; i++) order_q[i] <= TID_W'(i);
    end else if (rr_commit) begin
      order_q <= chain[NUM_SLOTS];
    end
  end

  logic [NUM_THREADS-1:0] present;
  always_comb begin
    present = '0;
    for (int i = 0; i < NUM_THREADS; i++) present[order_q[i]] = 1'b1;
  end

  // R2: the rotating list always holds every thread id exactly once
  a_r2_list_permutation: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(present) == NUM_THREADS);

  // R6: drain or no fetch request leaves every slot empty
  a_r6_drain_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_req || !fetch_en) |-> (&sel_none));

  // R10: the list is stable across edges without a rotating grant
  a_r10_list_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rr_commit |=> $stable(order_q));

  // R8: fixed rule with several threads grants thread 0 in slot 0
  a_r8_fixed_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (MULTI && policy == POL_FIXED0 && fetch_en && !drain_req)
      |-> (!sel_none[0] && sel_tid[TID_W-1:0] == '0));

endmodule

// File: tb/test_fetch_thread_selector.sv
module test_fetch_thread_selector;

  localparam int CLK_P = 10;
  localparam int NT    = 4;
  localparam int NS    = 2;
  localparam int OW    = 5;
  localparam int TW    = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic            fe, drn;
  logic [1:0]      pol;
  logic [NT*3-1:0] st;
  logic [NT-1:0]   act;
  logic [NT*OW-1:0] iq, lsq;
  logic [NS-1:0]   none_o;
  logic [NS*TW-1:0] tid_o;

  logic [2:0]      st1;
  logic [0:0]      act1;
  logic [OW-1:0]   iq1, lsq1;
  logic [NS-1:0]   none1;
  logic [NS-1:0]   tid1;

  fetch_thread_selector #(.NUM_THREADS(NT), .NUM_SLOTS(NS), .OCC_W(OW)) i_fetch_thread_selector (
    .clk(clk), .rst_n(rst_n), .fetch_en(fe), .drain_req(drn), .policy(pol),
    .thread_state(st), .thread_active(act), .iq_occ(iq), .lsq_occ(lsq),
    .sel_none(none_o), .sel_tid(tid_o)
  );

  fetch_thread_selector #(.NUM_THREADS(1), .NUM_SLOTS(NS), .OCC_W(OW)) i_fetch_thread_selector_one (
    .clk(clk), .rst_n(rst_n), .fetch_en(fe), .drain_req(drn), .policy(pol),
    .thread_state(st1), .thread_active(act1), .iq_occ(iq1), .lsq_occ(lsq1),
    .sel_none(none1), .sel_tid(tid1)
  );

  int n_chk = 0;
  int n_bad = 0;
  int m_order [NT];
  logic [31:0] lcg = 32'h1234_5679;

  function automatic bit can_go(int code, bit a);
    return a && (code == 0 || code == 1 || code == 6);
  endfunction

  task automatic check(bit ok, string req, int slot, int g_n, int g_t, int e_n, int e_t);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s slot%0d: got none=%0d tid=%0d, expected none=%0d tid=%0d",
               req, slot, g_n, g_t, e_n, e_t);
    end
  endtask

  // reference model of the four-thread instance, applied from the requirements
  task automatic eval_main(string force_tag);
    int  lst [NT];
    bit  en;
    bit  any0;
    any0 = 0;
    for (int i = 0; i < NT; i++) lst[i] = m_order[i];
    en = fe && !drn;                          // R6
    for (int s = 0; s < NS; s++) begin
      bit found;
      int tid;
      string tag;
      found = 0;
      tid   = 0;
      if (en) begin
        case (pol)
          2'd0: found = 1;                    // R8
          2'd1: begin                         // R2 head-first scan, move to tail
            int p;
            p = -1;
            for (int i = 0; i < NT; i++)
              if (p < 0 && can_go(int'(st[lst[i]*3 +: 3]), act[lst[i]])) p = i;
            if (p >= 0) begin
              found = 1;
              tid = lst[p];
              for (int i = p; i < NT - 1; i++) lst[i] = lst[i+1];
              lst[NT-1] = tid;
            end
          end
          default: begin                      // R7 least occupancy, lower id on tie
            int best;
            best = 0;
            for (int t = 0; t < NT; t++) begin
              int o;
              o = (pol == 2'd2) ? int'(iq[t*OW +: OW]) : int'(lsq[t*OW +: OW]);
              if (can_go(int'(st[t*3 +: 3]), act[t]) && (!found || o < best)) begin
                found = 1; best = o; tid = t;
              end
            end
          end
        endcase
      end
      if (s == 0) any0 = found;
      if (force_tag != "") tag = force_tag;
      else if (!(fe && !drn)) tag = "R6";
      else if (s > 0 && !any0) tag = "R5";
      else if (!found) tag = "R4";
      else if (pol == 2'd0) tag = "R8";
      else if (pol == 2'd1) tag = (s == 0) ? "R2" : "R5";
      else tag = "R7";
      check((none_o[s] == !found) && (int'(tid_o[s*TW +: TW]) == tid), tag, s,
            int'(none_o[s]), int'(tid_o[s*TW +: TW]), int'(!found), tid);
      if (!found) en = 0;
    end
    // R10: the model list moves only after a rotating grant in slot 0
    if (pol == 2'd1 && any0)
      for (int i = 0; i < NT; i++) m_order[i] = lst[i];
  endtask

  task automatic step_main(string tag);
    #(CLK_P/4);
    eval_main(tag);
    @(negedge clk);
  endtask

  initial begin
    fe = 0; drn = 0; pol = 2'd1; st = '0; act = '0; iq = '0; lsq = '0;
    st1 = '0; act1 = '0; iq1 = '0; lsq1 = '0;
    for (int i = 0; i < NT; i++) m_order[i] = i;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R3: ascending start order, seen through two slots over two cycles
    fe = 1; drn = 0; pol = 2'd1; st = '0; act = '1;
    step_main("R3");
    step_main("R3");

    // R1: every non-fetchable state code blocks the thread
    st = {3'd2, 3'd3, 3'd4, 3'd5};
    step_main("R1");
    st = {3'd7, 3'd3, 3'd4, 3'd6};
    step_main("R1");
    st = {3'd1, 3'd1, 3'd1, 3'd1}; act = 4'b0000;
    step_main("R1");

    // R10: no-grant cycles leave the order as it was
    act = 4'b1111; drn = 1;
    step_main("R10");
    drn = 0;
    step_main("R10");

    // near-exhaustive sweep over state codes and policies
    for (int p = 0; p < 4096; p++) begin
      for (int k = 0; k < 4; k++) begin
        int cyc;
        cyc = p * 4 + k;
        lcg = lcg * 32'd1103515245 + 32'd12345;
        st  = p[11:0];
        pol = k[1:0];
        act = lcg[19:16];
        for (int t = 0; t < NT; t++) begin
          iq[t*OW +: OW]  = OW'(lcg[t*2 +: 2]);
          lsq[t*OW +: OW] = OW'(lcg[t*2 + 8 +: 2]);
        end
        drn = (cyc % 9) == 4;
        fe  = (cyc % 11) != 7;
        step_main("");
      end
    end

    // R9: single-thread instance ignores the policy
    for (int c = 0; c < 8; c++) begin
      for (int a = 0; a < 2; a++) begin
        for (int q = 0; q < 4; q++) begin
          for (int d = 0; d < 2; d++) begin
            bit g;
            st1 = c[2:0]; act1 = a[0:0]; pol = q[1:0]; drn = d[0]; fe = 1;
            iq1 = OW'(c); lsq1 = OW'(q);
            #(CLK_P/4);
            g = can_go(c, a[0]) && !d[0];
            for (int s = 0; s < NS; s++)
              check(none1[s] == !g && tid1[s] == 1'b0, "R9", s,
                    int'(none1[s]), int'(tid1[s]), int'(!g), 0);
            @(negedge clk);
          end
        end
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule